// File: doc/BRIEF.md
# Virtual cache tag store with split privilege valid bits

This block keeps the tags for a direct-mapped cache that is indexed and tagged with logical (pre-translation) addresses. The cache has 4096 lines of one 32-bit word each. Every line carries one stored tag and two valid flags, one for user-mode and one for supervisor-mode accesses. The privilege of an access picks which flag is checked and which flag a fill sets. Software can therefore discard every cached user line without losing supervisor lines, and the reverse.

On each cycle the block compares the stored tag and the selected valid flag against the presented address while the address strobe is high, and reports a first-level hit. A second-level read hit also requires a translation-buffer hit whenever mapping is active for the cycle. That read hit lets the surrounding logic end the processor cycle from cache data, with no external bus access. Line fills write the tag and set the selected flag. Each of the two purges walks its own flag array, clearing one row of flags per clock.

Top module: `vtag_cache`

## Requirements
- R1: Address bits 1:0 are the byte offset and take no part in a lookup. Bits 13:2 are the line index, and bits 31:14 are the stored tag. A different tag at the same index misses.
- R2: `hit_o` is 1 only when `as_i` is 1, the stored tag at the index equals the address tag, and the selected valid flag is set.
- R3: Each line has a user flag and a supervisor flag. `super_i`=1 selects the supervisor flag and `super_i`=0 selects the user flag, for both lookup and fill.
- R4: If `umap_en_i`=0 or `smap_en_i`=0, the supervisor flag is selected whatever the value of `super_i`.
- R5: `fast_rd_o` is 1 when `hit_o` is 1, `write_i`=0, and either `map_cycle_i`=0 or `tlb_hit_i`=1. It is 0 otherwise.
- R6: A fill (`fill_i`=1 at a clock edge) writes the address tag to the indexed line and sets only the selected flag. The other flag of that line keeps its value. A lookup hits from the next cycle on.
- R7: A fill with `write_i`=1 is ignored, so a write miss allocates nothing. A write to a line that hits leaves the line valid.
- R8: A one-cycle pulse on `purge_user_i` clears every user flag and leaves every supervisor flag untouched. `purge_busy_o[0]` is 1 for exactly 2**IDX_W/2**LANE_W cycles after the request edge (64 at defaults). It then falls, and `purge_done_o[0]` pulses for one cycle at the same edge.
- R9: `purge_super_i` does the same for the supervisor flags, using `purge_busy_o[1]` and `purge_done_o[1]`. It leaves the user flags untouched. Both purges may run at the same time.
- R10: While the selected flag array is being purged, `hit_o` is 0 and a fill to that array is ignored.
- R11: After reset every flag is clear, both busy bits are 0 and both done bits are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 32 | Logical address of the access |
| super_i | input | 1 | 1 = supervisor access, 0 = user access |
| as_i | input | 1 | Address strobe |
| write_i | input | 1 | 1 = write, 0 = read |
| map_cycle_i | input | 1 | Address translation active for this cycle |
| tlb_hit_i | input | 1 | Translation buffer hit for this cycle |
| umap_en_i | input | 1 | User mapping enabled |
| smap_en_i | input | 1 | Supervisor mapping enabled |
| fill_i | input | 1 | Line fill: write tag and set selected flag |
| purge_user_i | input | 1 | Start clearing all user flags |
| purge_super_i | input | 1 | Start clearing all supervisor flags |
| hit_o | output | 1 | First-level hit |
| fast_rd_o | output | 1 | Read hit that ends the cycle without a bus access |
| purge_busy_o | output | 2 | Purge in progress, bit 0 user, bit 1 supervisor |
| purge_done_o | output | 2 | One-cycle purge completion pulse, bit 0 user, bit 1 supervisor |

## Verification
The bench builds the block with IDX_W=6 and LANE_W=3. This gives 64 lines in 8 purge rows, so the tag field becomes bits 31:8 and a full purge sweep takes 8 cycles. With these values a test can observe a complete purge and measure its busy length. It can also fill a line in row 0 after that row has already been swept, which shows whether fills are blocked during a purge. Tag aliasing at one index, independence of the two flags, and the mapping-off override are reached with a handful of directed addresses.

// File: rtl/vtag_pkg.sv
package vtag_pkg;
  typedef enum logic {
    PRIV_USER  = 1'b0,
    PRIV_SUPER = 1'b1
  } priv_e;

  localparam int unsigned NUM_PRIV = 2;
endpackage

// File: rtl/vtag_store.sv
module vtag_store #(
  parameter int unsigned IDX_W = 12,
  parameter int unsigned TAG_W = 18
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic [TAG_W-1:0] wr_tag_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic [TAG_W-1:0] rd_tag_o
);
  localparam int unsigned ENTRIES = 1 << IDX_W;

  // No reset: tag contents are meaningless until a flag is set
  logic [TAG_W-1:0] mem_q [ENTRIES];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[wr_idx_i] <= wr_tag_i;
  end

  assign rd_tag_o = mem_q[rd_idx_i];
endmodule

// File: rtl/vtag_valid_bank.sv
module vtag_valid_bank #(
  parameter int unsigned IDX_W  = 12,
  parameter int unsigned LANE_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             purge_req_i,
  input  logic             set_i,
  input  logic [IDX_W-1:0] set_idx_i,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_vld_o,
  output logic             busy_o,
  output logic             done_o
);
  localparam int unsigned ENTRIES = 1 << IDX_W;
  localparam int unsigned LANES   = 1 << LANE_W;
  localparam int unsigned ROWS    = ENTRIES / LANES;
  localparam int unsigned ROW_W   = IDX_W - LANE_W;

  logic [LANES-1:0] vld_q [ROWS];
  logic [ROW_W-1:0] cnt_q;
  logic             busy_q, done_q;

  logic [ROW_W-1:0]  set_row, rd_row;
  logic [LANE_W-1:0] set_lane, rd_lane;

  assign set_row  = set_idx_i[IDX_W-1:LANE_W];
  assign set_lane = set_idx_i[LANE_W-1:0];
  assign rd_row   = rd_idx_i[IDX_W-1:LANE_W];
  assign rd_lane  = rd_idx_i[LANE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < int'(ROWS); r++) vld_q[r] <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (purge_req_i) begin
        // a new request restarts the sweep
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        vld_q[cnt_q] <= '0;
        cnt_q        <= cnt_q + 1'b1;
        if (cnt_q == ROW_W'(ROWS - 1)) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
      if (set_i) vld_q[set_row][set_lane] <= 1'b1;
    end
  end

  assign rd_vld_o = vld_q[rd_row][rd_lane];
  assign busy_o   = busy_q;
  assign done_o   = done_q;
endmodule

// File: rtl/vtag_hit.sv
module vtag_hit #(
  parameter int unsigned TAG_W = 18
) (
  input  logic             as_i,
  input  logic             write_i,
  input  logic             map_cycle_i,
  input  logic             tlb_hit_i,
  input  logic [TAG_W-1:0] stored_tag_i,
  input  logic [TAG_W-1:0] req_tag_i,
  input  logic             vld_i,
  input  logic             busy_i,
  output logic             hit_o,
  output logic             fast_rd_o
);
  logic lvl1, lvl2;

  assign lvl1      = as_i && vld_i && !busy_i && (stored_tag_i == req_tag_i);
  assign lvl2      = lvl1 && (!map_cycle_i || tlb_hit_i);
  assign hit_o     = lvl1;
  assign fast_rd_o = lvl2 && !write_i;
endmodule

// File: rtl/vtag_cache.sv
module vtag_cache #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFF_W  = 2,
  parameter int unsigned IDX_W  = 12,
  parameter int unsigned LANE_W = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              super_i,
  input  logic              as_i,
  input  logic              write_i,
  input  logic              map_cycle_i,
  input  logic              tlb_hit_i,
  input  logic              umap_en_i,
  input  logic              smap_en_i,
  input  logic              fill_i,
  input  logic              purge_user_i,
  input  logic              purge_super_i,
  output logic              hit_o,
  output logic              fast_rd_o,
  output logic [1:0]        purge_busy_o,
  output logic [1:0]        purge_done_o
);
  import vtag_pkg::*;

  localparam int unsigned TAG_W  = ADDR_W - IDX_W - OFF_W;
  localparam int unsigned TAG_LO = OFF_W + IDX_W;

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] req_tag, stored_tag;
  logic             unused_off;
  priv_e            sel;
  logic [NUM_PRIV-1:0] vld, busy, done, req, set;
  logic             fill_ok;

  assign idx        = addr_i[TAG_LO-1:OFF_W];
  assign req_tag    = addr_i[ADDR_W-1:TAG_LO];
  assign unused_off = ^addr_i[OFF_W-1:0];

  // mapping off on either side forces the supervisor flags
  assign sel = (super_i || !umap_en_i || !smap_en_i) ? PRIV_SUPER : PRIV_USER;

  assign fill_ok = fill_i && !write_i && !busy[sel];
  assign req     = {purge_super_i, purge_user_i};

  vtag_store #(
    .IDX_W (IDX_W),
    .TAG_W (TAG_W)
  ) u_store (
    .clk_i    (clk_i),
    .we_i     (fill_ok),
    .wr_idx_i (idx),
    .wr_tag_i (req_tag),
    .rd_idx_i (idx),
    .rd_tag_o (stored_tag)
  );

  for (genvar p = 0; p < NUM_PRIV; p++) begin : g_bank
    assign set[p] = fill_ok && (sel == priv_e'(p));

    vtag_valid_bank #(
      .IDX_W  (IDX_W),
      .LANE_W (LANE_W)
    ) u_bank (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .purge_req_i (req[p]),
      .set_i       (set[p]),
      .set_idx_i   (idx),
      .rd_idx_i    (idx),
      .rd_vld_o    (vld[p]),
      .busy_o      (busy[p]),
      .done_o      (done[p])
    );
  end

  vtag_hit #(
    .TAG_W (TAG_W)
  ) u_hit (
    .as_i         (as_i),
    .write_i      (write_i),
    .map_cycle_i  (map_cycle_i),
    .tlb_hit_i    (tlb_hit_i),
    .stored_tag_i (stored_tag),
    .req_tag_i    (req_tag),
    .vld_i        (vld[sel]),
    .busy_i       (busy[sel]),
    .hit_o        (hit_o),
    .fast_rd_o    (fast_rd_o)
  );

  assign purge_busy_o = busy;
  assign purge_done_o = done;
endmodule

// File: rtl/vtag_cache_chk.sv
module vtag_cache_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       as_i,
  input logic       write_i,
  input logic       map_cycle_i,
  input logic       tlb_hit_i,
  input logic       purge_user_i,
  input logic       purge_super_i,
  input logic       hit_o,
  input logic       fast_rd_o,
  input logic [1:0] purge_busy_o,
  input logic [1:0] purge_done_o
);
  p_no_strobe_no_hit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !as_i |-> !hit_o);

  p_fast_is_read_hit_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fast_rd_o |-> (hit_o && !write_i));

  p_fast_needs_tlb_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fast_rd_o && map_cycle_i) |-> tlb_hit_i);

  p_busy_blocks_hit_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&purge_busy_o) |-> !hit_o);

  p_user_start_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    purge_user_i |=> purge_busy_o[0]);

  p_super_start_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    purge_super_i |=> purge_busy_o[1]);

  p_user_done_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    purge_done_o[0] |-> (!purge_busy_o[0] && $past(purge_busy_o[0])));

  p_super_done_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    purge_done_o[1] |-> (!purge_busy_o[1] && $past(purge_busy_o[1])));
endmodule

bind vtag_cache vtag_cache_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .as_i          (as_i),
  .write_i       (write_i),
  .map_cycle_i   (map_cycle_i),
  .tlb_hit_i     (tlb_hit_i),
  .purge_user_i  (purge_user_i),
  .purge_super_i (purge_super_i),
  .hit_o         (hit_o),
  .fast_rd_o     (fast_rd_o),
  .purge_busy_o  (purge_busy_o),
  .purge_done_o  (purge_done_o)
);

// File: tb/vtag_cache_tb.sv
module vtag_cache_tb;
  localparam int IDX_W  = 6;
  localparam int LANE_W = 3;
  localparam int ENT    = 1 << IDX_W;
  localparam int ROWS   = ENT >> LANE_W;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic [31:0] addr_i = '0;
  logic super_i = 0, as_i = 0, write_i = 0, map_cycle_i = 0, tlb_hit_i = 0;
  logic umap_en_i = 1, smap_en_i = 1, fill_i = 0, purge_user_i = 0, purge_super_i = 0;
  logic hit_o, fast_rd_o;
  logic [1:0] purge_busy_o, purge_done_o;

  vtag_cache #(.IDX_W(IDX_W), .LANE_W(LANE_W)) u_dut (.*);

  always #2 clk_i = ~clk_i;

  int total = 0, bad = 0;

  // reference model built from the requirements
  logic [23:0] m_tag [ENT];
  logic        m_uv  [ENT];
  logic        m_sv  [ENT];
  logic        m_bu = 0, m_bs = 0;

  // scoreboard queues
  logic  q_hit  [$];
  logic  q_fast [$];
  string q_req  [$];

  task automatic chk(input logic act, input logic exp, input string req);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0b exp=%0b", req, act, exp);
    end
  endtask

  task automatic look(input logic [31:0] a, input logic sup, wr, asv, mapc, tlb,
                      um, sm, fl, input string req);
    int   ix;
    logic sel_s, v, b, eh;
    @(negedge clk_i);
    addr_i = a; super_i = sup; write_i = wr; as_i = asv; map_cycle_i = mapc;
    tlb_hit_i = tlb; umap_en_i = um; smap_en_i = sm; fill_i = fl;
    ix    = int'(a[7:2]);
    sel_s = sup | ~um | ~sm;
    v     = sel_s ? m_sv[ix] : m_uv[ix];
    b     = sel_s ? m_bs : m_bu;
    eh    = asv && v && !b && (m_tag[ix] == a[31:8]);
    q_hit.push_back(eh);
    q_fast.push_back(eh && !wr && (!mapc || tlb));
    q_req.push_back(req);
    if (fl && !wr && !b) begin
      m_tag[ix] = a[31:8];
      if (sel_s) m_sv[ix] = 1'b1; else m_uv[ix] = 1'b1;
    end
  endtask

  task automatic idle();
    @(negedge clk_i);
    as_i = 0; fill_i = 0; write_i = 0;
  endtask

  // monitor: compares results away from the clock edge
  always @(negedge clk_i) begin
    #1;
    if (q_hit.size() > 0) begin
      logic eh, ef;
      string r;
      eh = q_hit.pop_front(); ef = q_fast.pop_front(); r = q_req.pop_front();
      chk(hit_o, eh, {r, " hit"});
      chk(fast_rd_o, ef, {r, " fast"});
    end
  end

  // pulse the purge request(s) for one cycle
  task automatic purge_start(input logic u, input logic s);
    @(negedge clk_i);
    purge_user_i = u; purge_super_i = s;
    @(negedge clk_i);
    purge_user_i = 0; purge_super_i = 0;
    if (u) m_bu = 1;
    if (s) m_bs = 1;
  endtask

  // finish an ongoing purge: count busy cycles already seen plus remaining
  task automatic purge_wait(input int bit_i, input int seen, input string req);
    int n = seen;
    logic done_seen = 0;
    for (int k = 0; k < 4 * ROWS; k++) begin
      #1;
      if (purge_busy_o[bit_i]) n++;
      else begin
        done_seen = purge_done_o[bit_i];
        break;
      end
      @(negedge clk_i);
    end
    total++;
    if (n != ROWS) begin
      bad++;
      $display("FAIL %s busy_cycles act=%0d exp=%0d", req, n, ROWS);
    end
    chk(done_seen, 1'b1, {req, " done pulse"});
    for (int e = 0; e < ENT; e++) begin
      if (bit_i == 0) m_uv[e] = 0; else m_sv[e] = 0;
    end
    if (bit_i == 0) m_bu = 0; else m_bs = 0;
  endtask

  localparam logic [31:0] A  = 32'h1234_5674;
  localparam logic [31:0] B  = 32'h0000_0010;
  localparam logic [31:0] C  = 32'hABCD_0040;
  localparam logic [31:0] D0 = 32'h5555_5500;

  initial begin
    for (int e = 0; e < ENT; e++) begin
      m_tag[e] = '0; m_uv[e] = 0; m_sv[e] = 0;
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    #1;
    // R11 reset state
    chk(purge_busy_o[0], 0, "R11 busy user");
    chk(purge_busy_o[1], 0, "R11 busy super");
    chk(purge_done_o[0], 0, "R11 done user");
    chk(purge_done_o[1], 0, "R11 done super");
    look(A, 0, 0, 1, 0, 0, 1, 1, 0, "R11 empty lookup");
    look(32'h0, 1, 0, 1, 0, 0, 1, 1, 0, "R11 empty lookup super");

    // R6 fill user then hit
    look(A, 0, 0, 1, 0, 0, 1, 1, 1, "R6 fill miss");
    look(A, 0, 0, 1, 0, 0, 1, 1, 0, "R6 user hit");
    look(A, 1, 0, 1, 0, 0, 1, 1, 0, "R3 super flag clear");
    look(A | 32'h3, 0, 0, 1, 0, 0, 1, 1, 0, "R1 offset ignored");
    look(A + 32'h100, 0, 0, 1, 0, 0, 1, 1, 0, "R1 alias tag");
    look(A, 0, 0, 0, 0, 0, 1, 1, 0, "R2 no strobe");

    // R5 second level
    look(A, 0, 0, 1, 1, 0, 1, 1, 0, "R5 mapped tlb miss");
    look(A, 0, 0, 1, 1, 1, 1, 1, 0, "R5 mapped tlb hit");
    look(A, 0, 1, 1, 0, 0, 1, 1, 0, "R5 R7 write hit");
    look(A, 0, 0, 1, 0, 0, 1, 1, 0, "R7 still valid after write");

    // R7 write miss no allocate
    look(B, 0, 1, 1, 0, 0, 1, 1, 1, "R7 write fill");
    look(B, 0, 0, 1, 0, 0, 1, 1, 0, "R7 no allocate");

    // R4 mapping off uses supervisor flag
    look(C, 0, 0, 1, 0, 0, 0, 1, 1, "R4 fill umap off");
    look(C, 1, 0, 1, 0, 0, 1, 1, 0, "R4 super sees fill");
    look(C, 0, 0, 1, 0, 0, 1, 1, 0, "R4 user flag clear");
    look(C, 0, 0, 1, 0, 0, 1, 0, 0, "R4 smap off");

    // R6 other flag unchanged: add supervisor flag to A
    look(A, 1, 0, 1, 0, 0, 1, 1, 1, "R6 fill super");
    look(A, 0, 0, 1, 0, 0, 1, 1, 0, "R6 user kept");
    look(A, 1, 0, 1, 0, 0, 1, 1, 0, "R6 super set");

    // R8 user purge
    idle();
    purge_start(1, 0);
    purge_wait(0, 0, "R8");
    look(A, 0, 0, 1, 0, 0, 1, 1, 0, "R8 user cleared");
    look(A, 1, 0, 1, 0, 0, 1, 1, 0, "R8 super kept");
    look(C, 1, 0, 1, 0, 0, 1, 1, 0, "R8 super kept C");

    // R9 R10 supervisor purge with activity during sweep
    look(A, 0, 0, 1, 0, 0, 1, 1, 1, "R9 refill user");
    idle();
    purge_start(0, 1);
    look(A, 1, 0, 1, 0, 0, 1, 1, 0, "R10 miss while busy");
    look(A, 0, 0, 1, 0, 0, 1, 1, 0, "R9 user live");
    look(D0, 1, 0, 1, 0, 0, 1, 1, 1, "R10 fill blocked");
    idle();
    purge_wait(1, 4, "R9");
    look(D0, 1, 0, 1, 0, 0, 1, 1, 0, "R10 blocked fill absent");
    look(A, 1, 0, 1, 0, 0, 1, 1, 0, "R9 super cleared");
    look(A, 0, 0, 1, 0, 0, 1, 1, 0, "R9 user kept");

    // R9 both purges together
    idle();
    purge_start(1, 1);
    #1;
    chk(purge_busy_o[0], 1, "R9 both busy user");
    chk(purge_busy_o[1], 1, "R9 both busy super");
    purge_wait(0, 0, "R9 both user");
    #1;
    chk(purge_busy_o[1], 0, "R9 both super ended");
    m_bs = 0;
    for (int e = 0; e < ENT; e++) m_sv[e] = 0;
    look(A, 0, 0, 1, 0, 0, 1, 1, 0, "R9 both user cleared");
    idle();
    idle();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    bad++;
    total++;
    $display("FAIL watchdog act=timeout exp=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule